// File: doc/BRIEF.md
# Current-Sense Blanking and Overcurrent Detector

This block watches the primary-side current-sense path of a switched-mode power stage. A raw fast comparator bit arrives from an analog sensor. A blanking timer masks that bit for a programmable time after each switching-cycle anchor, so the turn-on current spike cannot cause a false trip. Once the window has elapsed, the first high sample produces a single-cycle fast-trip pulse. The anchor is either the cycle-start pulse or, in auxiliary mode, the rising edge of the auxiliary drive output.

A separate, slower path compares each completed current-sense ADC sample against a 5-bit limit. The limit is left-aligned onto the ADC word, and its low bits are zero. A sample strictly above that threshold latches a sticky flag. The flag stays set until a write-one-to-clear input or reset.

The blanking timer uses two states. `BLK_OPEN` passes the comparator, and an anchor with a non-zero code moves it to `BLK_HOLD`. `BLK_HOLD` counts down the window: a fresh anchor reloads the count, and an expired count returns to `BLK_OPEN`. The accurate path also uses two states. `OCP_CLEAR` moves to `OCP_LATCHED` on a qualifying sample. `OCP_LATCHED` returns to `OCP_CLEAR` on a clear request only when no qualifying sample arrives in the same cycle.

Top module: `csense_ocp_guard`

## Requirements
- R1: Blanking codes 1 to 7 mask the comparator for N clock cycles, counting the anchor cycle. N is the delay rounded up to whole clock periods. The delays are: code 1 = 40 ns, code 2 = 80 ns, code 3 = 120 ns, code 4 = 200 ns, code 5 = 400 ns, code 6 = 600 ns, code 7 = 800 ns. At the default 5 ns period, N is 8, 16, 24, 40, 80, 120 and 160 cycles.
- R2: While the window is active, a high comparator input produces no fast-trip pulse. After the window ends, a comparator held high since the anchor trips exactly N cycles after the anchor edge.
- R3: Blanking code 0 applies no mask. A high comparator sample at clock edge E yields fast_trip high in the cycle after E.
- R4: With aux_mode = 1, the window is anchored on a rising edge of aux_drive, and cyc_start has no effect. With aux_mode = 0, cyc_start anchors the window and aux_drive has no effect.
- R5: An anchor that arrives while a window is active restarts the full window from that anchor.
- R6: fast_trip is a one-cycle pulse. It is raised on the first unmasked high sample, and a comparator that stays high produces no further pulse.
- R7: The accurate flag is set only on a cycle with adc_valid = 1 and adc_code strictly greater than ocp_limit shifted left by (ADC_W - 5). A sample equal to that threshold does not set the flag.
- R8: The accurate flag stays set until ocp_clr = 1. If a qualifying sample and ocp_clr arrive in the same cycle, the flag stays set.
- R9: After reset, fast_trip and ocp_flag are low and the blanking window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Switching-cycle start pulse |
| aux_drive | input | 1 | Auxiliary drive output level |
| aux_mode | input | 1 | 1: anchor on aux_drive rising edge |
| blank_code | input | 3 | Blanking delay select |
| cmp_raw | input | 1 | Raw fast comparator bit |
| adc_valid | input | 1 | ADC sample strobe |
| adc_code | input | ADC_W | Current-sense ADC sample |
| ocp_limit | input | 5 | Accurate overcurrent limit |
| ocp_clr | input | 1 | Write-one-to-clear for ocp_flag |
| fast_trip | output | 1 | Qualified fast overcurrent pulse |
| ocp_flag | output | 1 | Sticky accurate overcurrent flag |

## Verification
Some properties are checked by the embedded assertions on every cycle:
- a masked cycle is never followed by a trip;
- a trip never lasts two cycles;
- a zero-code anchor leaves the timer open;
- an expiring count returns to the open state;
- the accurate flag neither falls without a clear nor rises without a strobe.

Other behaviour only the bench scenarios can show. These are the exact trip cycle for each of the eight codes, the auxiliary re-anchoring and the ignored cycle-start, and the window restart. They also include the strict-greater-than boundary at both ends of the limit range.

// File: rtl/csg_pkg.sv
package csg_pkg;

    typedef enum logic {BLK_OPEN, BLK_HOLD} blk_state_e;
    typedef enum logic {OCP_CLEAR, OCP_LATCHED} ocp_state_e;

    function automatic int unsigned blank_ns(input logic [2:0] code);
        int unsigned ns;
        case (code)
            3'd0:    ns = 0;
            3'd1:    ns = 40;
            3'd2:    ns = 80;
            3'd3:    ns = 120;
            3'd4:    ns = 200;
            3'd5:    ns = 400;
            3'd6:    ns = 600;
            default: ns = 800;
        endcase
        return ns;
    endfunction

    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

endpackage

// File: rtl/csg_anchor_sel.sv
module csg_anchor_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic aux_drive,
    input  logic aux_mode,
    output logic anchor
);
    logic aux_q;
    logic aux_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) aux_q <= 1'b0;
        else        aux_q <= aux_drive;
    end

    assign aux_rise = aux_drive & ~aux_q;
    assign anchor   = aux_mode ? aux_rise : cyc_start;
endmodule

// File: rtl/csg_blank_fsm.sv
module csg_blank_fsm
    import csg_pkg::*;
#(
    parameter int unsigned PERIOD_PS = 5000,
    parameter int unsigned CNT_W     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       anchor,
    input  logic [2:0] blank_code,
    output logic       blank_mask
);
    logic [CNT_W-1:0] win_tbl [8];
    blk_state_e       state, nxt_state;
    logic [CNT_W-1:0] cnt, nxt_cnt;
    logic [CNT_W-1:0] win_len;

    for (genvar i = 0; i < 8; i++) begin : g_tbl
        assign win_tbl[i] = CNT_W'(ns_to_cycles(blank_ns(3'(i)), PERIOD_PS));
    end

    assign win_len = win_tbl[blank_code];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BLK_OPEN;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        if (anchor) begin
            if (win_len <= CNT_W'(1)) begin
                nxt_state = BLK_OPEN;
                nxt_cnt   = '0;
            end else begin
                nxt_state = BLK_HOLD;
                nxt_cnt   = win_len - CNT_W'(1);
            end
        end else begin
            unique case (state)
                BLK_OPEN: begin
                    nxt_state = BLK_OPEN;
                end
                BLK_HOLD: begin
                    if (cnt <= CNT_W'(1)) begin
                        nxt_state = BLK_OPEN;
                        nxt_cnt   = '0;
                    end else begin
                        nxt_cnt = cnt - CNT_W'(1);
                    end
                end
            endcase
        end
    end

    always_comb begin
        blank_mask = (state == BLK_HOLD) || (anchor && (win_len != '0));
    end

    // R3: an anchor with code zero never opens a hold window
    a_r3_zero_code_open: assert property (@(posedge clk) disable iff (!rst_n)
        (anchor && blank_code == 3'd0) |=> (state == BLK_OPEN));

    // R1: the last hold count returns the timer to the open state
    a_r1_hold_expires: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BLK_HOLD && cnt == CNT_W'(1) && !anchor) |=> (state == BLK_OPEN));
endmodule

// File: rtl/csg_trip_qual.sv
module csg_trip_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_raw,
    input  logic blank_mask,
    output logic fast_trip
);
    logic qual, qual_q;

    assign qual = cmp_raw & ~blank_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qual_q    <= 1'b0;
            fast_trip <= 1'b0;
        end else begin
            qual_q    <= qual;
            fast_trip <= qual & ~qual_q;
        end
    end

    // R2: a masked sample is never followed by a trip
    a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        blank_mask |=> !fast_trip);

    // R6: the trip lasts one cycle only
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fast_trip |=> !fast_trip);
endmodule

// File: rtl/csg_accurate_ocp.sv
module csg_accurate_ocp
    import csg_pkg::*;
#(
    parameter int unsigned ADC_W   = 10,
    parameter int unsigned LIMIT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adc_valid,
    input  logic [ADC_W-1:0]   adc_code,
    input  logic [LIMIT_W-1:0] ocp_limit,
    input  logic               ocp_clr,
    output logic               ocp_flag
);
    localparam int unsigned SHIFT = ADC_W - LIMIT_W;

    logic [ADC_W-1:0] thr;
    logic             over;
    ocp_state_e       state, nxt_state;

    if (SHIFT == 0) begin : g_thr_direct
        assign thr = ocp_limit;
    end else begin : g_thr_aligned
        assign thr = {ocp_limit, {SHIFT{1'b0}}};
    end

    assign over = adc_valid && (adc_code > thr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OCP_CLEAR;
        else        state <= nxt_state;
    end

    always_comb begin
        nxt_state = state;
        unique case (state)
            OCP_CLEAR:   if (over) nxt_state = OCP_LATCHED;
            OCP_LATCHED: if (ocp_clr && !over) nxt_state = OCP_CLEAR;
        endcase
    end

    always_comb begin
        ocp_flag = (state == OCP_LATCHED);
    end

    // R8: the flag only falls on a clear request
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ocp_flag && !ocp_clr) |=> ocp_flag);

    // R7: the flag only rises on a valid sample
    a_r7_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!ocp_flag && !adc_valid) |=> !ocp_flag);
endmodule

// File: rtl/csense_ocp_guard.sv
module csense_ocp_guard
    import csg_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 5000,
    parameter int unsigned ADC_W         = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic             aux_drive,
    input  logic             aux_mode,
    input  logic [2:0]       blank_code,
    input  logic             cmp_raw,
    input  logic             adc_valid,
    input  logic [ADC_W-1:0] adc_code,
    input  logic [4:0]       ocp_limit,
    input  logic             ocp_clr,
    output logic             fast_trip,
    output logic             ocp_flag
);
    localparam int unsigned MAX_CYC = ns_to_cycles(blank_ns(3'd7), CLK_PERIOD_PS);
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1) + 1;

    logic anchor;
    logic blank_mask;

    csg_anchor_sel u_anchor (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .aux_drive (aux_drive),
        .aux_mode  (aux_mode),
        .anchor    (anchor)
    );

    csg_blank_fsm #(
        .PERIOD_PS (CLK_PERIOD_PS),
        .CNT_W     (CNT_W)
    ) u_blank (
        .clk        (clk),
        .rst_n      (rst_n),
        .anchor     (anchor),
        .blank_code (blank_code),
        .blank_mask (blank_mask)
    );

    csg_trip_qual u_trip (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_raw    (cmp_raw),
        .blank_mask (blank_mask),
        .fast_trip  (fast_trip)
    );

    csg_accurate_ocp #(
        .ADC_W   (ADC_W),
        .LIMIT_W (5)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .adc_valid (adc_valid),
        .adc_code  (adc_code),
        .ocp_limit (ocp_limit),
        .ocp_clr   (ocp_clr),
        .ocp_flag  (ocp_flag)
    );
endmodule

// File: tb/sim_csense_ocp_guard.sv
module sim_csense_ocp_guard;
    localparam int ADC_W = 10;

    typedef struct {
        int    cyc;
        string req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cyc_start = 1'b0;
    logic             aux_drive = 1'b0;
    logic             aux_mode = 1'b0;
    logic [2:0]       blank_code = 3'd0;
    logic             cmp_raw = 1'b0;
    logic             adc_valid = 1'b0;
    logic [ADC_W-1:0] adc_code = '0;
    logic [4:0]       ocp_limit = 5'd0;
    logic             ocp_clr = 1'b0;
    logic             fast_trip;
    logic             ocp_flag;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fails = 0;
    exp_t sb[$];

    csense_ocp_guard u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_start  (cyc_start),
        .aux_drive  (aux_drive),
        .aux_mode   (aux_mode),
        .blank_code (blank_code),
        .cmp_raw    (cmp_raw),
        .adc_valid  (adc_valid),
        .adc_code   (adc_code),
        .ocp_limit  (ocp_limit),
        .ocp_clr    (ocp_clr),
        .fast_trip  (fast_trip),
        .ocp_flag   (ocp_flag)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int win_cycles(input int code);
        int ns;
        case (code)
            0: ns = 0;
            1: ns = 40;
            2: ns = 80;
            3: ns = 120;
            4: ns = 200;
            5: ns = 400;
            6: ns = 600;
            default: ns = 800;
        endcase
        return (ns * 1000 + 4999) / 5000;
    endfunction

    task automatic push_exp(input int at, input string req);
        exp_t e;
        e.cyc = at;
        e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: every fast_trip pulse is matched against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && fast_trip) begin
            n_checks++;
            if (sb.size() == 0) begin
                n_fails++;
                $display("FAIL R2 unexpected trip: actual cycle %0d, expected none", cyc);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.cyc != cyc) begin
                    n_fails++;
                    $display("FAIL %s trip cycle: actual %0d, expected %0d", e.req, cyc, e.cyc);
                end
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b, expected %b", req, act, exp);
        end
    endtask

    // Anchor a window and hold the comparator high from the anchor cycle.
    task automatic trip_case(input int code, input bit use_aux, input string req);
        int n;
        n = win_cycles(code);
        @(negedge clk);
        blank_code = 3'(code);
        aux_mode   = use_aux;
        if (use_aux) aux_drive = 1'b1;
        else         cyc_start = 1'b1;
        cmp_raw = 1'b1;
        push_exp(cyc + 1 + n, req);
        @(negedge clk);
        cyc_start = 1'b0;
        repeat (n + 4) @(negedge clk);
        cmp_raw   = 1'b0;
        aux_drive = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // cyc_start in auxiliary mode must not open a window.
    task automatic ignored_start_case();
        @(negedge clk);
        aux_mode   = 1'b1;
        blank_code = 3'd7;
        cyc_start  = 1'b1;
        cmp_raw    = 1'b1;
        push_exp(cyc + 1, "R4");
        @(negedge clk);
        cyc_start = 1'b0;
        repeat (4) @(negedge clk);
        cmp_raw = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // aux_drive rising edge in cycle-start mode must not open a window.
    task automatic ignored_aux_case();
        @(negedge clk);
        aux_mode   = 1'b0;
        blank_code = 3'd7;
        aux_drive  = 1'b1;
        cmp_raw    = 1'b1;
        push_exp(cyc + 1, "R4");
        repeat (5) @(negedge clk);
        cmp_raw   = 1'b0;
        aux_drive = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic restart_case();
        @(negedge clk);
        aux_mode   = 1'b0;
        blank_code = 3'd1;
        cyc_start  = 1'b1;
        cmp_raw    = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        repeat (4) @(negedge clk);
        cyc_start = 1'b1;
        push_exp(cyc + 1 + win_cycles(1), "R5");
        @(negedge clk);
        cyc_start = 1'b0;
        repeat (14) @(negedge clk);
        cmp_raw = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic acc_step(input bit v, input int code, input int lim, input bit clr,
                            input logic exp, input string req);
        @(negedge clk);
        adc_valid = v;
        adc_code  = ADC_W'(code);
        ocp_limit = 5'(lim);
        ocp_clr   = clr;
        @(negedge clk);
        adc_valid = 1'b0;
        ocp_clr   = 1'b0;
        check(req, ocp_flag, exp);
    endtask

    initial begin
        #400000;
        n_fails++;
        $display("FAIL watchdog: actual timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 fast_trip after reset", fast_trip, 1'b0);
        check("R9 ocp_flag after reset", ocp_flag, 1'b0);

        // R9: window open straight after reset, no anchor needed
        blank_code = 3'd7;
        cmp_raw    = 1'b1;
        push_exp(cyc + 1, "R9");
        repeat (5) @(negedge clk);
        cmp_raw = 1'b0;
        repeat (3) @(negedge clk);

        trip_case(0, 1'b0, "R3");
        for (int c = 1; c < 8; c++) trip_case(c, 1'b0, "R1");
        trip_case(2, 1'b1, "R4");
        trip_case(5, 1'b1, "R4");
        trip_case(0, 1'b1, "R3");
        ignored_start_case();
        ignored_aux_case();
        restart_case();

        // R6: every case above held the comparator high for several
        // cycles; the monitor flags any extra pulse. Now confirm none pending.
        n_checks++;
        if (sb.size() != 0) begin
            n_fails++;
            $display("FAIL R6 missing trips: actual %0d pending, expected 0", sb.size());
        end

        // Accurate path, ADC_W=10: threshold = limit * 32
        acc_step(1'b1, 96, 3, 1'b0, 1'b0, "R7 equal to threshold");
        acc_step(1'b0, 1023, 3, 1'b0, 1'b0, "R7 no strobe");
        acc_step(1'b1, 97, 3, 1'b0, 1'b1, "R7 above threshold");
        acc_step(1'b1, 0, 3, 1'b0, 1'b1, "R8 sticky on low sample");
        acc_step(1'b0, 0, 3, 1'b0, 1'b1, "R8 sticky idle");
        acc_step(1'b0, 0, 3, 1'b1, 1'b0, "R8 clear");
        acc_step(1'b1, 200, 3, 1'b1, 1'b1, "R8 set wins over clear");
        acc_step(1'b0, 0, 3, 1'b1, 1'b0, "R8 clear again");
        acc_step(1'b1, 992, 31, 1'b0, 1'b0, "R7 top limit equal");
        acc_step(1'b1, 1023, 31, 1'b0, 1'b1, "R7 top limit above");
        acc_step(1'b0, 0, 31, 1'b1, 1'b0, "R8 clear top");
        acc_step(1'b1, 0, 0, 1'b0, 1'b0, "R7 zero limit equal");
        acc_step(1'b1, 1, 0, 1'b0, 1'b1, "R7 zero limit above");

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule